// File: doc/BRIEF.md
# Rectangular frame-memory transfer address generator

This block moves a rectangle of 16-bit pixels between a host and a frame memory of 1024 by 512 halfwords. A start request carries a position word and a size word. The block then walks the rectangle in raster order and drives a simple synchronous RAM port with one pixel per cycle. In the write direction each accepted 32-bit host word is split into two pixels. When the mask input is high, bit 15 of every stored pixel is forced to 1. In the read direction two pixels read from memory are packed into one 32-bit word, which is returned with a valid strobe.

The walker state persists across host words. Because of this, a row may end in the middle of a word, the host may stall between words, and the transfer picks up at the saved column. Rows and columns that run off the frame edge wrap around. The busy flag covers the whole transfer. A second start request that arrives during a transfer is reported and otherwise has no effect.

Top module: `rect_xfer_agen`

## Requirements
- R1: Out of reset `busy_o`, `host_ready_o`, `mem_en_o`, `rd_valid_o` and `start_err_o` are all 0. A host word offered while idle is not taken, so `mem_en_o` stays 0.
- R2: The start column is `pos_word_i[9:0]` and the start line is `pos_word_i[24:16]`. The first memory address is line*1024 + column, and all other bits of the word are ignored.
- R3: Width is `((size_word_i[9:0] - 1) mod 1024) + 1` and height is `((size_word_i[24:16] - 1) mod 512) + 1`, so a zero field selects 1024 columns or 512 lines. Exactly width*height memory accesses are made.
- R4: Pixels are visited left to right along a line, and after `width` pixels the walk moves to the next line at the start column.
- R5: The column wraps modulo 1024 and the line wraps modulo 512 when the rectangle crosses the frame edge.
- R6: In the write direction, host bits 15:0 are stored first at the lower pixel position, and bits 31:16 are stored at the next position.
- R7: When `mask_set_i` is 1 during a write, the stored pixel has bit 15 set. When it is 0, the host value is stored unchanged.
- R8: In the read direction, the earlier pixel is returned in bits 15:0 and the later one in bits 31:16. `rd_valid_o` is high for one cycle, one cycle after the last memory read of that word. When the rectangle ends on the lower half of a word, bits 31:16 are 0.
- R9: `busy_o` rises the cycle after an accepted start and falls the cycle after the final pixel access. With an odd pixel count, the unused upper half of the last host word is dropped.
- R10: A host word whose two pixels straddle a line end places its second pixel at the start column of the next line.
- R11: A start request while busy raises `start_err_o` for one cycle. It does not change the geometry or direction of the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request |
| dir_rd_i | input | 1 | Direction of the requested transfer, 1 = read from memory |
| pos_word_i | input | 32 | Position word: column and line of the top-left pixel |
| size_word_i | input | 32 | Size word: width and height fields |
| mask_set_i | input | 1 | Force bit 15 of written pixels |
| start_err_o | output | 1 | Pulse: start request refused because busy |
| busy_o | output | 1 | Transfer in progress |
| host_valid_i | input | 1 | Host offers a word (write data or read request) |
| host_wdata_i | input | 32 | Host write word, two pixels |
| host_ready_o | output | 1 | Block takes a host word this cycle |
| rd_word_o | output | 32 | Packed read word |
| rd_valid_o | output | 1 | Read word valid strobe |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 19 | Pixel address line*1024 + column |
| mem_wdata_o | output | 16 | Pixel write data |
| mem_rdata_i | input | 16 | Pixel read data, one cycle after the read |

## Verification
A column or line counter that steps wrongly shows up within a few cycles as a wrong `mem_addr_o`. An error in the wrap logic shows up as soon as the walk reaches the frame edge. A lost or stuck word phase shows at the memory port as a swapped or repeated pixel half in the same word. In the read direction it shows as a misplaced half in `rd_word_o`. A bad end-of-rectangle decision shows as an access count different from width*height, or as `busy_o` staying high once the last word has been handed over.

// File: rtl/rect_xfer_pkg.sv
// Shared constants and geometry type for the rectangle transfer block.
// Assumes a power-of-two frame so that coordinate wrap is plain truncation.
package rect_xfer_pkg;
    localparam int XW    = 10;          // log2 of frame width in pixels
    localparam int YW    = 9;           // log2 of frame height in lines
    localparam int PIX_W = 16;          // bits per pixel
    localparam int AW    = XW + YW;     // pixel address width
    localparam int HW_W  = 2 * PIX_W;   // host word width

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [YW-1:0] y0;
        logic [XW-1:0] w_m1;
        logic [YW-1:0] h_m1;
    } rect_geom_t;
endpackage

// File: rtl/rect_geom_decode.sv
// Decodes a position word and a size word into start corner and size-minus-one.
// Assumes size fields use minus-one modular coding, so a zero field means full range.
module rect_geom_decode
    import rect_xfer_pkg::*;
#(
    parameter int POS_Y_LSB  = 16,
    parameter int SIZE_H_LSB = 16
) (
    input  logic [HW_W-1:0] pos_word_i,
    input  logic [HW_W-1:0] size_word_i,
    output rect_geom_t      geom_o
);
    // Field extraction; the subtraction wraps inside the field width.
    always_comb begin
        geom_o.x0   = pos_word_i[XW-1:0];
        geom_o.y0   = pos_word_i[POS_Y_LSB +: YW];
        geom_o.w_m1 = size_word_i[XW-1:0] - 1'b1;
        geom_o.h_m1 = size_word_i[SIZE_H_LSB +: YW] - 1'b1;
    end
endmodule

// File: rtl/rect_raster_walk.sv
// Holds the rectangle geometry and the column/line offsets of the current pixel.
// Produces the wrapped pixel address and a flag for the final pixel.
// Assumes step_i is only asserted while a transfer is active.
module rect_raster_walk
    import rect_xfer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  rect_geom_t    geom_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    rect_geom_t    g_q;
    logic [XW-1:0] col_q;
    logic [YW-1:0] row_q;
    logic          row_end;
    logic [XW-1:0] x_cur;
    logic [YW-1:0] y_cur;

    // End-of-line and end-of-rectangle detection.
    always_comb begin
        row_end = (col_q == g_q.w_m1);
        last_o  = row_end && (row_q == g_q.h_m1);
        x_cur   = g_q.x0 + col_q;
        y_cur   = g_q.y0 + row_q;
        addr_o  = {y_cur, x_cur};
    end

    // Geometry latch and raster offset counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q   <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (load_i) begin
            g_q   <= geom_i;
            col_q <= '0;
            row_q <= '0;
        end else if (step_i) begin
            if (row_end) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // R4: after the last column of a non-final line the column restarts at zero.
    p_line_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && row_end && !last_o) |=> (col_q == '0));

    // R11: geometry never changes except on a load.
    p_geom_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(g_q));
endmodule

// File: rtl/rect_read_pack.sv
// Packs two pixels read from memory into one host word.
// Assumes memory read data arrives one cycle after the read enable.
module rect_read_pack
    import rect_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic             phase_i,
    input  logic             word_end_i,
    input  logic [PIX_W-1:0] mem_rdata_i,
    output logic [HW_W-1:0]  rd_word_o,
    output logic             rd_valid_o
);
    logic             cap_q;
    logic             half_q;
    logic             valid_q;
    logic [PIX_W-1:0] low_q;

    // Tracks which read is in flight and when a word is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= 1'b0;
            half_q  <= 1'b0;
            valid_q <= 1'b0;
            low_q   <= '0;
        end else begin
            cap_q   <= rd_en_i && !phase_i;
            valid_q <= rd_en_i && word_end_i;
            half_q  <= rd_en_i && word_end_i && !phase_i;
            if (cap_q) begin
                low_q <= mem_rdata_i;
            end
        end
    end

    // Word assembly: the live memory data is the newest pixel.
    always_comb begin
        rd_valid_o = valid_q;
        rd_word_o  = half_q ? {{PIX_W{1'b0}}, mem_rdata_i} : {mem_rdata_i, low_q};
    end

    // R8: a returned word always follows a memory read by one cycle.
    p_valid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_en_i));
endmodule

// File: rtl/rect_xfer_agen.sv
// Top of the rectangle transfer address generator.
// Accepts a start request, then moves one pixel per cycle between host words and a
// synchronous single-port pixel memory. Assumes the memory returns read data one
// cycle after a read and that the host holds write data while host_valid_i is high.
module rect_xfer_agen
    import rect_xfer_pkg::*;
#(
    parameter int POS_Y_LSB  = 16,
    parameter int SIZE_H_LSB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_rd_i,
    input  logic [HW_W-1:0]  pos_word_i,
    input  logic [HW_W-1:0]  size_word_i,
    input  logic             mask_set_i,
    output logic             start_err_o,
    output logic             busy_o,
    input  logic             host_valid_i,
    input  logic [HW_W-1:0]  host_wdata_i,
    output logic             host_ready_o,
    output logic [HW_W-1:0]  rd_word_o,
    output logic             rd_valid_o,
    output logic             mem_en_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [PIX_W-1:0] mem_wdata_o,
    input  logic [PIX_W-1:0] mem_rdata_i
);
    rect_geom_t      geom_in;
    logic            busy_q;
    logic            dir_rd_q;
    logic            word_act_q;
    logic            phase_q;
    logic            err_q;
    logic [HW_W-1:0] wword_q;
    logic            accept_start;
    logic            word_take;
    logic            last_pix;
    logic            word_end;
    logic [PIX_W-1:0] pix_sel;

    rect_geom_decode #(
        .POS_Y_LSB (POS_Y_LSB),
        .SIZE_H_LSB(SIZE_H_LSB)
    ) i_decode (
        .pos_word_i (pos_word_i),
        .size_word_i(size_word_i),
        .geom_o     (geom_in)
    );

    rect_raster_walk i_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(accept_start),
        .geom_i(geom_in),
        .step_i(word_act_q),
        .addr_o(mem_addr_o),
        .last_o(last_pix)
    );

    rect_read_pack i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (word_act_q && dir_rd_q),
        .phase_i    (phase_q),
        .word_end_i (word_end),
        .mem_rdata_i(mem_rdata_i),
        .rd_word_o  (rd_word_o),
        .rd_valid_o (rd_valid_o)
    );

    // Handshake and per-cycle memory port decode.
    always_comb begin
        accept_start = start_i && !busy_q;
        host_ready_o = busy_q && !word_act_q;
        word_take    = host_valid_i && host_ready_o;
        word_end     = word_act_q && (phase_q || last_pix);
        mem_en_o     = word_act_q;
        mem_we_o     = word_act_q && !dir_rd_q;
        pix_sel      = phase_q ? wword_q[HW_W-1:PIX_W] : wword_q[PIX_W-1:0];
        mem_wdata_o  = pix_sel | {mask_set_i, {(PIX_W-1){1'b0}}};
        busy_o       = busy_q;
        start_err_o  = err_q;
    end

    // Transfer control: busy, direction, word phase and refused-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            dir_rd_q   <= 1'b0;
            word_act_q <= 1'b0;
            phase_q    <= 1'b0;
            err_q      <= 1'b0;
            wword_q    <= '0;
        end else begin
            err_q <= start_i && busy_q;
            if (accept_start) begin
                busy_q   <= 1'b1;
                dir_rd_q <= dir_rd_i;
            end
            if (word_take) begin
                word_act_q <= 1'b1;
                phase_q    <= 1'b0;
                wword_q    <= host_wdata_i;
            end else if (word_act_q) begin
                phase_q <= !phase_q;
                if (word_end) begin
                    word_act_q <= 1'b0;
                end
                if (last_pix) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // R11: a refused start can only follow a busy cycle.
    p_err_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |-> $past(busy_o));

    // R9: memory is only touched during a transfer.
    p_mem_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> busy_o);

    // R9: the busy flag only drops right after a pixel access.
    p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mem_en_o));

    // R7: forced mask bit reaches the memory on every write.
    p_mask_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mask_set_i) |-> mem_wdata_o[PIX_W-1]);

    // R8: a read transfer never writes memory.
    p_read_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && dir_rd_q) |-> !mem_we_o);
endmodule

// File: tb/test_rect_xfer_agen.sv
module test_rect_xfer_agen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [31:0] pos;
        logic [31:0] size;
        logic        rd;
        logic        mask;
        logic [2:0]  salt;
    } vec_t;

    // Vector table: position, size, read flag, mask, data salt.
    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0005_000A, 32'h0003_0004, 1'b0, 1'b0, 3'd1},  // R2 R4 R6 plain write
        '{32'h0007_03FC, 32'h0002_0008, 1'b0, 1'b1, 3'd2},  // R5 column wrap, R7 mask
        '{32'h01FE_0003, 32'h0004_0003, 1'b0, 1'b0, 3'd3},  // R5 line wrap, R10 straddle
        '{32'h0064_00C8, 32'h0003_0005, 1'b0, 1'b0, 3'd4},  // R9 odd count
        '{32'h0005_000A, 32'h0003_0004, 1'b1, 1'b0, 3'd0},  // R8 read back vector 0
        '{32'h01FE_0003, 32'h0001_0003, 1'b1, 1'b0, 3'd0},  // R8 odd read, half word
        '{32'h0002_0000, 32'h0001_0000, 1'b0, 1'b0, 3'd5},  // R3 zero width = 1024
        '{32'h0009_0258, 32'h0000_0001, 1'b0, 1'b1, 3'd6},  // R3 zero height = 512
        '{32'hFE03_FC05, 32'hFC02_F802, 1'b0, 1'b0, 3'd7}   // R2 R3 stray upper bits
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_rd_i = 1'b0;
    logic [31:0] pos_word_i = '0;
    logic [31:0] size_word_i = '0;
    logic        mask_set_i = 1'b0;
    logic        start_err_o;
    logic        busy_o;
    logic        host_valid_i = 1'b0;
    logic [31:0] host_wdata_i = '0;
    logic        host_ready_o;
    logic [31:0] rd_word_o;
    logic        rd_valid_o;
    logic        mem_en_o;
    logic        mem_we_o;
    logic [18:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;

    int tests = 0;
    int fails = 0;

    logic [15:0] vmem [int];
    int          log_addr [$];
    logic [15:0] log_data [$];
    logic        log_we [$];
    logic [31:0] rd_log [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rect_xfer_agen i_rect_xfer_agen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_rd_i    (dir_rd_i),
        .pos_word_i  (pos_word_i),
        .size_word_i (size_word_i),
        .mask_set_i  (mask_set_i),
        .start_err_o (start_err_o),
        .busy_o      (busy_o),
        .host_valid_i(host_valid_i),
        .host_wdata_i(host_wdata_i),
        .host_ready_o(host_ready_o),
        .rd_word_o   (rd_word_o),
        .rd_valid_o  (rd_valid_o),
        .mem_en_o    (mem_en_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i)
    );

    function automatic logic [15:0] mem_peek(int a);
        if (vmem.exists(a)) return vmem[a];
        return 16'(a * 7 + 3) ^ 16'h2A2A;
    endfunction

    function automatic logic [15:0] pix_val(int p, logic [2:0] salt);
        return {1'b0, salt, 12'(p)};
    endfunction

    // Memory model: synchronous single port, read data one cycle later.
    always @(posedge clk) begin
        if (mem_en_o) begin
            if (mem_we_o) vmem[int'(mem_addr_o)] = mem_wdata_o;
            else mem_rdata_i <= mem_peek(int'(mem_addr_o));
        end
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_en_o) begin
            log_addr.push_back(int'(mem_addr_o));
            log_data.push_back(mem_wdata_o);
            log_we.push_back(mem_we_o);
        end
        if (rd_valid_o) rd_log.push_back(rd_word_o);
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        int w, h, n, nw, x0, y0, bad_a, bad_d, first_a, first_e;
        logic [15:0] exp_pix [$];
        log_addr.delete(); log_data.delete(); log_we.delete(); rd_log.delete();
        x0 = int'(v.pos & 32'h3FF);
        y0 = int'((v.pos >> 16) & 32'h1FF);
        w  = int'(((v.size - 1) & 32'h3FF) + 1);
        h  = int'((((v.size >> 16) - 1) & 32'h1FF) + 1);
        n  = w * h;
        nw = (n + 1) / 2;
        // Expected read pixels come from the model before the transfer runs.
        for (int p = 0; p < n; p++)
            exp_pix.push_back(mem_peek(((y0 + p / w) % 512) * 1024 + (x0 + p % w) % 1024));
        @(negedge clk);
        pos_word_i = v.pos; size_word_i = v.size; dir_rd_i = v.rd; mask_set_i = v.mask;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", 64'(busy_o), 64'd1);
        check(start_err_o == 1'b0, "R11 no error on idle start", 64'(start_err_o), 64'd0);
        if (poke) begin
            pos_word_i = 32'h0000_0000; size_word_i = 32'h0001_0001; dir_rd_i = ~v.rd;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(start_err_o == 1'b1, "R11 start while busy flagged", 64'(start_err_o), 64'd1);
            @(negedge clk);
            check(start_err_o == 1'b0, "R11 error is a single pulse", 64'(start_err_o), 64'd0);
        end
        for (int k = 0; k < nw; k++) begin
            while (!host_ready_o) @(negedge clk);
            host_valid_i = 1'b1;
            host_wdata_i = {pix_val(2 * k + 1, v.salt), pix_val(2 * k, v.salt)};
            @(negedge clk);
            host_valid_i = 1'b0;
        end
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R9 busy clears after last pixel", 64'(busy_o), 64'd0);
        check(log_addr.size() == n, "R3 access count", 64'(log_addr.size()), 64'(n));
        bad_a = 0; bad_d = 0; first_a = 0; first_e = 0;
        for (int p = 0; p < n && p < log_addr.size(); p++) begin
            int ea;
            logic [15:0] ed;
            ea = ((y0 + p / w) % 512) * 1024 + (x0 + p % w) % 1024;
            if (log_addr[p] != ea) begin
                if (bad_a == 0) begin first_a = log_addr[p]; first_e = ea; end
                bad_a++;
            end
            ed = pix_val(p, v.salt) | (v.mask ? 16'h8000 : 16'h0000);
            if (log_we[p] != !v.rd || (!v.rd && log_data[p] != ed)) bad_d++;
        end
        check(bad_a == 0, "R2 R4 R5 R10 address sequence", 64'(first_a), 64'(first_e));
        if (!v.rd) begin
            check(bad_d == 0, "R6 R7 write pixel data", 64'(bad_d), 64'd0);
        end else begin
            check(bad_d == 0, "R8 no writes in read", 64'(bad_d), 64'd0);
            check(rd_log.size() == nw, "R8 read word count", 64'(rd_log.size()), 64'(nw));
            for (int k = 0; k < nw && k < rd_log.size(); k++) begin
                logic [31:0] ew;
                ew[15:0]  = exp_pix[2 * k];
                ew[31:16] = (2 * k + 1 < n) ? exp_pix[2 * k + 1] : 16'h0000;
                check(rd_log[k] == ew, "R8 read word packing", 64'(rd_log[k]), 64'(ew));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && host_ready_o == 1'b0, "R1 idle in reset",
              64'({busy_o, host_ready_o}), 64'd0);
        check(mem_en_o == 1'b0 && rd_valid_o == 1'b0 && start_err_o == 1'b0, "R1 outputs quiet in reset",
              64'({mem_en_o, rd_valid_o, start_err_o}), 64'd0);
        rst_n = 1'b1;
        host_valid_i = 1'b1; host_wdata_i = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check(mem_en_o == 1'b0 && host_ready_o == 1'b0, "R1 host word ignored while idle",
              64'({mem_en_o, host_ready_o}), 64'd0);
        host_valid_i = 1'b0;

        // Table walk.
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], 1'b0);

        // Directed: start while busy is refused and leaves the transfer intact (R11).
        run_vec('{32'h0020_0030, 32'h0002_0005, 1'b0, 1'b0, 3'd2}, 1'b1);
        // Directed: refused start during a read transfer (R11, R8).
        run_vec('{32'h0020_0030, 32'h0002_0005, 1'b1, 1'b0, 3'd0}, 1'b1);
        // Directed: width 1 puts each half of a word on its own line (R10).
        run_vec('{32'h0040_0011, 32'h0004_0001, 1'b0, 1'b1, 3'd3}, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule